// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It holds a small byte-wide register file. A master addresses it with a control byte. The top seven bits of that byte hold the device address and the last bit selects the direction. With the direction bit clear, the master then sends a word address and one data byte. The data byte is written to the array when the master ends the command with a STOP.

The STOP also starts a write cycle of programmable length, counted in system clock ticks. While that cycle runs, the block refuses every control byte, so the master finds out when the cycle is over by sending START and the control byte again until it gets an acknowledge.

Reads use the same control byte with the direction bit set. A read returns the byte at an internal pointer, which always points one past the last location accessed. A random read first sets the pointer with a write command that carries only a word address, then issues a repeated START with the read bit set. Each master acknowledge during a read returns the next byte. Both bus lines are synchronised into the system clock domain before any decoding.

Top module: `eep_2w_slave`

## Requirements
- R1: A falling data line while the clock line is high (both synchronised) is a START; a rising data line while the clock line is high is a STOP. Data bits are sampled on rising clock edges, MSB first.
- R2: A control byte of {DEV_ADDR[6:0], 0}, then a word address byte (its low ADDR_W bits used), then one data byte, each acknowledged by pulling data low for one bit time. This stores the byte at that address when STOP arrives.
- R3: From the STOP that commits a write, for WR_TICKS clocks, every control byte (either direction) is not acknowledged. After that it is acknowledged again.
- R4: A write command carrying only a word address, followed by a repeated START and a control byte {DEV_ADDR, 1}, returns the byte stored at that address.
- R5: A read with no preceding address returns the byte at the last accessed address plus one, whether that access was a write or a read.
- R6: Read data is driven MSB first, changing only while the clock is low. A master no-acknowledge followed by STOP ends the read and releases the data line.
- R7: During a read, each master acknowledge causes the next byte to be sent. The pointer wraps from 2^ADDR_W-1 to 0.
- R8: A control byte whose upper seven bits differ from DEV_ADDR is not acknowledged, and the block does not pull the data line low until the next START.
- R9: A repeated START that arrives after a data byte but before STOP discards that byte. No write takes place and no write cycle starts.
- R10: After reset the array holds zeros, the pointer is 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Data line as seen on the wire (wired-AND of all drivers and pull-up) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 leaves it to the pull-up |

## Verification
Both lines pass two synchroniser flops and one edge register. The data line output therefore moves three system clocks after the clock line falls. The bench holds each clock-line phase ten system clocks and samples the wire in the middle of the high phase, well after that latency.

A committed write makes the block busy on the clock after the STOP is decoded. The bench's first poll completes only about 240 clocks later, inside the 300-tick cycle it configures. So one refused poll is expected before the acknowledge.

Sequential, wrapped, aborted and mismatched transfers are checked byte by byte at the data-line level.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CTRL_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_HOLD
    } state_e;
endpackage

// File: rtl/eep_line_sync.sv
`timescale 1ns/1ps
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_p_q, sda_p_q;

    // idle bus is high, so every flop resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sr_q <= {scl_sr_q[STAGES-2:0], scl_i};
            sda_sr_q <= {sda_sr_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sr_q[STAGES-1];
            sda_p_q  <= sda_sr_q[STAGES-1];
        end
    end

    assign scl_s    = scl_sr_q[STAGES-1];
    assign sda_s    = sda_sr_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_p  = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_p   = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/eep_regfile.sv
`timescale 1ns/1ps
module eep_regfile #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eep_wr_timer.sv
`timescale 1ns/1ps
module eep_wr_timer #(
    parameter int TICKS = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);
    localparam logic [CW-1:0] DEC  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - DEC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_2w_slave.sv
`timescale 1ns/1ps
module eep_2w_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 4,
    parameter int         WR_TICKS    = 500_000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    import eep_pkg::*;

    localparam logic [3:0]        LAST_BIT = 4'(BYTE_W);
    localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

    typedef struct packed {
        state_e              st;
        logic [3:0]          bits;
        logic [BYTE_W-1:0]   sh;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   waddr;
        logic [BYTE_W-1:0]   wdat;
        logic                wpend;
        logic                rw;
        logic                mack;
        logic                pull;
    } ctl_t;

    ctl_t st_d, st_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic busy, mem_we, t_start;
    logic [BYTE_W-1:0] rd_data;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    eep_regfile #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(st_q.waddr),
        .wdata(st_q.wdat), .raddr(st_q.ptr), .rdata(rd_data)
    );

    eep_wr_timer #(.TICKS(WR_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .busy(busy)
    );

    always_comb begin
        st_d    = st_q;
        mem_we  = 1'b0;
        t_start = 1'b0;
        if (start_p) begin
            // any START, repeated or not, drops an uncommitted byte
            st_d.st    = S_CTRL;
            st_d.bits  = '0;
            st_d.pull  = 1'b0;
            st_d.wpend = 1'b0;
        end else if (stop_p) begin
            st_d.st   = S_IDLE;
            st_d.pull = 1'b0;
            if (st_q.wpend) begin
                mem_we      = 1'b1;
                t_start     = 1'b1;
                st_d.wpend  = 1'b0;
                st_d.ptr    = st_q.waddr + ONE_A;
            end
        end else begin
            unique case (st_q.st)
                S_CTRL, S_ADDR, S_WDATA: begin
                    if (scl_rise && st_q.bits < LAST_BIT) begin
                        st_d.sh   = {st_q.sh[BYTE_W-2:0], sda_s};
                        st_d.bits = st_q.bits + 4'd1;
                    end else if (scl_fall && st_q.bits == LAST_BIT) begin
                        if (st_q.st == S_CTRL) begin
                            if (st_q.sh[7:1] == DEV_ADDR && !busy) begin
                                st_d.st   = S_CTRL_ACK;
                                st_d.pull = 1'b1;
                                st_d.rw   = st_q.sh[0];
                            end else begin
                                st_d.st = S_IDLE;
                            end
                        end else if (st_q.st == S_ADDR) begin
                            st_d.st   = S_ADDR_ACK;
                            st_d.pull = 1'b1;
                            st_d.ptr  = st_q.sh[ADDR_W-1:0];
                        end else begin
                            st_d.st    = S_WDATA_ACK;
                            st_d.pull  = 1'b1;
                            st_d.wdat  = st_q.sh;
                            st_d.waddr = st_q.ptr;
                            st_d.wpend = 1'b1;
                        end
                    end
                end
                S_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (st_q.rw) begin
                            st_d.st   = S_RDATA;
                            st_d.bits = '0;
                            st_d.sh   = rd_data;
                            st_d.pull = ~rd_data[BYTE_W-1];
                            st_d.ptr  = st_q.ptr + ONE_A;
                        end else begin
                            st_d.st   = S_ADDR;
                            st_d.bits = '0;
                            st_d.pull = 1'b0;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        st_d.st   = S_WDATA;
                        st_d.bits = '0;
                        st_d.pull = 1'b0;
                    end
                end
                S_WDATA_ACK: begin
                    if (scl_fall) begin
                        st_d.st   = S_HOLD;
                        st_d.pull = 1'b0;
                    end
                end
                S_RDATA: begin
                    if (scl_rise && st_q.bits < LAST_BIT) begin
                        st_d.bits = st_q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (st_q.bits == LAST_BIT) begin
                            st_d.st   = S_RACK;
                            st_d.pull = 1'b0;
                        end else begin
                            st_d.sh   = {st_q.sh[BYTE_W-2:0], 1'b0};
                            st_d.pull = ~st_q.sh[BYTE_W-2];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        st_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (st_q.mack) begin
                            st_d.st   = S_RDATA;
                            st_d.bits = '0;
                            st_d.sh   = rd_data;
                            st_d.pull = ~rd_data[BYTE_W-1];
                            st_d.ptr  = st_q.ptr + ONE_A;
                        end else begin
                            st_d.st   = S_HOLD;
                            st_d.pull = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: S_IDLE, bits: '0, sh: '0, ptr: '0, waddr: '0,
                      wdat: '0, wpend: 1'b0, rw: 1'b0, mack: 1'b0, pull: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    state_e     cur_state;
    logic [3:0] cur_bits;
    logic       cur_wpend;
    assign cur_state  = st_q.st;
    assign cur_bits   = st_q.bits;
    assign cur_wpend  = st_q.wpend;
    assign sda_pull_o = st_q.pull;
endmodule

// File: rtl/eep_2w_checker.sv
`timescale 1ns/1ps
module eep_2w_checker (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_rise,
    input logic            scl_fall,
    input logic            start_p,
    input logic            stop_p,
    input logic            busy,
    input logic            wpend,
    input logic            pull,
    input eep_pkg::state_e state,
    input logic [3:0]      bits
);
    import eep_pkg::*;

    a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, stop_p, scl_rise, scl_fall}));

    a_r1_start_opens_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (state == S_CTRL && bits == 4'd0 && !pull));

    a_r6_pull_moves_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_p && !stop_p) |=> $stable(pull));

    a_r2_stop_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_p && wpend) |=> busy);

    a_r3_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CTRL && bits == 4'd8 && scl_fall && busy && !start_p && !stop_p)
        |=> (state == S_IDLE && !pull));

    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !pull);
endmodule

bind eep_2w_slave eep_2w_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .busy(busy), .wpend(cur_wpend),
    .pull(sda_pull_o), .state(cur_state), .bits(cur_bits)
);

// File: tb/eep_2w_slave_bench.sv
`timescale 1ns/1ps
module eep_2w_slave_bench;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         TICK = 300;
    localparam int         HALF = 10;
    localparam int         NVEC = 10;

    // entry: op[17:16] (0 write, 1 random read, 2 current read), addr[15:8], data[7:0]
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 8'h03, 8'hA5},
        {2'd0, 8'h04, 8'h3C},
        {2'd0, 8'h0F, 8'h81},
        {2'd1, 8'h03, 8'hA5},
        {2'd2, 8'h00, 8'h3C},
        {2'd1, 8'h0F, 8'h81},
        {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h00, 8'h77},
        {2'd1, 8'h00, 8'h77},
        {2'd2, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n, scl, m_sda, pull;
    logic mon_en, pull_seen;
    int   n_chk, n_bad;
    wire  sda_line = m_sda & ~pull;

    always #4 clk = ~clk;

    eep_2w_slave #(.DEV_ADDR(DEV), .ADDR_W(4), .WR_TICKS(TICK)) u_eep_2w_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(pull)
    );

    always @(posedge clk) if (mon_en && pull) pull_seen <= 1'b1;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF);
        m_sda = 1'b0; tick(HALF);
        scl = 1'b0;   tick(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        scl = 1'b1;   tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(HALF);
            scl = 1'b1;   tick(HALF);
            scl = 1'b0;
        end
        m_sda = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF / 2);
        ack = ~sda_line;
        tick(HALF / 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl = 1'b1; tick(HALF / 2);
            b[i] = sda_line;
            tick(HALF / 2);
            scl = 1'b0;
        end
        m_sda = ~mack; tick(HALF);
        scl = 1'b1;    tick(HALF);
        scl = 1'b0;    m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v, output int polls);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); check("R2 ctrl ack", ack, 1);
        send_byte(a, ack);           check("R2 addr ack", ack, 1);
        send_byte(v, ack);           check("R2 data ack", ack, 1);
        bus_stop();
        polls = 0;
        for (int k = 0; k < 40; k++) begin
            bus_start();
            send_byte({DEV, 1'b0}, ack);
            if (ack) break;
            polls++;
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] v);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); check("R4 ctrl ack", ack, 1);
        send_byte(a, ack);           check("R4 addr ack", ack, 1);
        bus_start();
        send_byte({DEV, 1'b1}, ack); check("R4 read ack", ack, 1);
        recv_byte(v, 1'b0);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] v);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b1}, ack); check("R5 read ack", ack, 1);
        recv_byte(v, 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       ack;
        int         polls;
        n_chk = 0; n_bad = 0;
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; mon_en = 1'b0; pull_seen = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R10: released line, zero pointer, zero contents
        check("R10 line released", pull, 0);
        cur_read(v);
        check("R10 addr 0 reads zero", v, 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            case (VEC[k][17:16])
                2'd0: begin
                    do_write(VEC[k][15:8], VEC[k][7:0], polls);
                    check("R3 first poll refused", polls >= 1, 1);
                end
                2'd1: begin
                    rand_read(VEC[k][15:8], v);
                    check("R4 R6 random read", v, VEC[k][7:0]);
                end
                default: begin
                    cur_read(v);
                    check("R5 R7 current read", v, VEC[k][7:0]);
                end
            endcase
        end

        // R7: sequential read across the top of the array
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h0F, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack); check("R7 read ack", ack, 1);
        recv_byte(v, 1'b1); check("R7 byte at F", v, 8'h81);
        recv_byte(v, 1'b1); check("R7 wrapped to 0", v, 8'h77);
        recv_byte(v, 1'b0); check("R7 byte at 1", v, 8'h00);
        bus_stop();

        // R8: foreign device address
        bus_start();
        pull_seen = 1'b0; mon_en = 1'b1;
        send_byte({7'h51, 1'b1}, ack);
        tick(HALF);
        mon_en = 1'b0;
        check("R8 no ack", ack, 0);
        check("R8 line never pulled", pull_seen, 0);
        bus_stop();

        // R9: repeated START before STOP discards the data byte
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h02, ack);
        send_byte(8'h99, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack); check("R9 no write cycle started", ack, 1);
        recv_byte(v, 1'b0);          check("R9 addr 2 unchanged", v, 8'h00);
        bus_stop();
        rand_read(8'h02, v);         check("R9 addr 2 still zero", v, 8'h00);

        // R5: pointer follows a write
        do_write(8'h09, 8'h5A, polls);
        do_write(8'h08, 8'h12, polls);
        cur_read(v);
        check("R5 read after write to 8", v, 8'h5A);
        check("R6 line released after read", pull, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule